// File: doc/BRIEF.md
# Byte-Wide Passive FPGA Configuration Host

This block sits on the host side of a passive parallel configuration link. It pulls configuration bytes from a valid/ready byte stream. It presents each byte on an 8-bit bus and clocks it into the target with a generated configuration clock that runs at half the system clock. A configuration attempt opens with a timed active-low request pulse. Streaming starts only once the target's active-low status line has been released. When the final byte is in, the clock runs on for a few extra cycles and is then parked low. The block waits for both the configuration-done and the initialization-done lines to go high.

A status drop while the link is active counts as a configuration error. The recovery path depends on an auto-restart input. With auto-restart set, the block waits without pulsing for the target to release status, then replays the image. With auto-restart clear, it issues a fresh request pulse. A done line that never rises in time also forces a fresh pulse. A retry counter caps the attempts, and once the cap is used up the block ends in a sticky failure state. The image source is told to start over from the first byte through a one-cycle rewind strobe.

Top module: `pp_cfg_host`

## Requirements
- R1: While `rst` is high and just after it falls, `cfg_req_n` is 1, `cfg_clk` is 0, and `s_ready`, `rewind`, `ok` and `fail` are all 0.
- R2: A `start` pulse in the idle or success state drives `cfg_req_n` low for at least `PULSE_CYC` system-clock cycles and then high. No byte is clocked into the target before `stat_n` is high.
- R3: Each byte sits on `cfg_data` for at least one full system-clock cycle before the `cfg_clk` rising edge that latches it. This also holds after a stall in the stream. Bytes are latched in stream order. While bytes keep coming, `cfg_clk` toggles on every system-clock cycle.
- R4: After the rising edge that latches the byte flagged by `s_last`, `cfg_clk` gives exactly 2 more rising edges when `comp_mode` is 0, or exactly 3 when `comp_mode` is 1. It is then held low, and no further byte is accepted.
- R5: Once the trailing edges are done, `ok` rises after `done_in` and `init_in` have both been seen high. It stays high until the next `start`.
- R6: If `stat_n` goes low while streaming, during the trailing edges or while waiting for done, streaming stops. `cfg_clk` settles low and `s_ready` drops.
- R7: With `auto_restart` at 1, an error does not pulse `cfg_req_n`. The block waits for `stat_n` to return high, then streams again from the first byte. It tolerates status low times from 500 to 25000 cycles (10 to 500 µs at 50 MHz). If status stays low for `STATUS_TO` cycles, it falls back to a request pulse.
- R8: With `auto_restart` at 0, an error causes a new `cfg_req_n` low pulse of at least `PULSE_CYC` cycles, followed by a full restream.
- R9: If `done_in` and `init_in` are not both high within `DONE_TO` cycles after the trailing edges, the block issues a new request pulse and reconfigures.
- R10: After `MAX_RETRY` retries, the next failure raises `fail`. From then until reset, `fail` stays high, `start` is ignored, `cfg_req_n` stays 1 and `cfg_clk` stays 0.
- R11: A `start` pulse in the success state drops `ok` on the next cycle and begins a new request pulse.
- R12: `rewind` is a one-cycle pulse issued at the start of every attempt, including every retry. The next byte accepted after it is the image's first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a (re)configuration |
| auto_restart | input | 1 | 1: recover from errors by waiting for status release |
| comp_mode | input | 1 | 1: image uses compression/security, 3 trailing clocks |
| s_data | input | 8 | Image byte from source |
| s_valid | input | 1 | Source byte valid |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Byte accepted when high with s_valid |
| rewind | output | 1 | One-cycle strobe: source restarts at first byte |
| cfg_req_n | output | 1 | Active-low configuration request to target |
| cfg_data | output | 8 | Configuration data bus |
| cfg_clk | output | 1 | Configuration clock, half system rate |
| stat_n | input | 1 | Target active-low status |
| done_in | input | 1 | Target configuration-done |
| init_in | input | 1 | Target initialization-done |
| ok | output | 1 | Configuration succeeded |
| fail | output | 1 | Sticky failure, retries exhausted |

## Verification
The assertions assume the target behaves like a real configuration target. It pulls `stat_n` low while `cfg_req_n` is low, it releases it only some cycles after the request ends, and it raises the done lines only after the image and the trailing clocks have arrived. They also assume the source holds `s_data` and `s_last` steady while `s_valid` waits for `s_ready`. The bench keeps to these rules by modelling the target as a small state machine driven from `cfg_req_n`, the count of captured edges and an injected error window. It drives every input on the falling system-clock edge, with `start` held high for exactly one cycle.

// File: rtl/pp_cfg_pkg.sv
package pp_cfg_pkg;

    localparam int BUS_W       = 8;
    localparam int TRAIL_PLAIN = 2;
    localparam int TRAIL_COMP  = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT_STAT,
        ST_STREAM,
        ST_TRAIL,
        ST_DONE_WAIT,
        ST_RECOVER,
        ST_SUCCESS,
        ST_FAIL
    } cfg_state_e;

    typedef struct packed {
        logic stat_n;
        logic done;
        logic init;
    } tgt_stat_s;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic [1:0] trail_len(input logic comp);
        return comp ? 2'(TRAIL_COMP) : 2'(TRAIL_PLAIN);
    endfunction

endpackage

// File: rtl/pp_cfg_sync.sv
module pp_cfg_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[b]}};
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/pp_cfg_timer.sv
module pp_cfg_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pp_cfg_shifter.sv
module pp_cfg_shifter
    import pp_cfg_pkg::*;
#(
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          trail,
    input  logic          comp_mode,
    input  logic          s_valid,
    input  logic [DW-1:0] s_data,
    input  logic          s_last,
    output logic          s_ready,
    output logic          cfg_clk,
    output logic [DW-1:0] cfg_data,
    output logic          last_latch,
    output logic          trail_done
);
    logic          clk_q, loaded_q, last_q;
    logic [DW-1:0] data_q;
    logic [1:0]    edge_cnt;
    logic          take;

    // accept while the clock is high (new byte appears at the falling edge)
    // or while idle-low with nothing loaded
    assign s_ready    = run && !last_q && (clk_q || !loaded_q);
    assign take       = s_ready && s_valid;
    assign last_latch = run && !clk_q && loaded_q && last_q;
    assign trail_done = trail && !clk_q && (edge_cnt == trail_len(comp_mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q    <= 1'b0;
            loaded_q <= 1'b0;
            last_q   <= 1'b0;
            data_q   <= '0;
            edge_cnt <= '0;
        end else if (run) begin
            edge_cnt <= '0;
            if (clk_q) begin
                clk_q <= 1'b0;
                if (take) begin
                    data_q   <= s_data;
                    loaded_q <= 1'b1;
                    last_q   <= s_last;
                end else begin
                    loaded_q <= 1'b0;
                end
            end else if (loaded_q) begin
                clk_q <= 1'b1;
            end else if (take) begin
                data_q   <= s_data;
                loaded_q <= 1'b1;
                last_q   <= s_last;
            end
        end else if (trail) begin
            loaded_q <= 1'b0;
            last_q   <= 1'b0;
            if (clk_q) begin
                clk_q <= 1'b0;
            end else if (edge_cnt != trail_len(comp_mode)) begin
                clk_q    <= 1'b1;
                edge_cnt <= edge_cnt + 1'b1;
            end
        end else begin
            clk_q    <= 1'b0;
            loaded_q <= 1'b0;
            last_q   <= 1'b0;
            edge_cnt <= '0;
        end
    end

    assign cfg_clk  = clk_q;
    assign cfg_data = data_q;

    AST_DATA_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_clk) |-> $stable(cfg_data)); // R3
endmodule

// File: rtl/pp_cfg_host.sv
module pp_cfg_host
    import pp_cfg_pkg::*;
#(
    parameter int PULSE_CYC   = 100,
    parameter int STATUS_TO   = 26000,
    parameter int DONE_TO     = 2000,
    parameter int MAX_RETRY   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             auto_restart,
    input  logic             comp_mode,
    input  logic [BUS_W-1:0] s_data,
    input  logic             s_valid,
    input  logic             s_last,
    output logic             s_ready,
    output logic             rewind,
    output logic             cfg_req_n,
    output logic [BUS_W-1:0] cfg_data,
    output logic             cfg_clk,
    input  logic             stat_n,
    input  logic             done_in,
    input  logic             init_in,
    output logic             ok,
    output logic             fail
);
    localparam int TW = $clog2(max3(PULSE_CYC, STATUS_TO, DONE_TO) + 1);
    localparam int RW = $clog2(MAX_RETRY + 2);
    localparam int LW = $clog2(PULSE_CYC + 2);
    localparam int SW = $bits(tgt_stat_s);

    cfg_state_e st, nxt;
    tgt_stat_s  tgt_raw, tgt;
    logic [RW-1:0] retry_q, retry_nxt;
    logic [TW-1:0] tmr_val;
    logic          tmr_ld, tmr_exp;
    logic          rew_q, rew_set;
    logic          fault, force_pulse;
    logic          last_latch, trail_done;
    logic          run, trail;

    assign tgt_raw = '{stat_n: stat_n, done: done_in, init: init_in};

    pp_cfg_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SW'(3'b100))) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (tgt_raw),
        .q   (tgt)
    );

    pp_cfg_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_ld),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    assign run   = (st == ST_STREAM);
    assign trail = (st == ST_TRAIL);

    pp_cfg_shifter #(.DW(BUS_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .trail      (trail),
        .comp_mode  (comp_mode),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .s_last     (s_last),
        .s_ready    (s_ready),
        .cfg_clk    (cfg_clk),
        .cfg_data   (cfg_data),
        .last_latch (last_latch),
        .trail_done (trail_done)
    );

    always_comb begin
        nxt         = st;
        tmr_ld      = 1'b0;
        tmr_val     = '0;
        rew_set     = 1'b0;
        retry_nxt   = retry_q;
        fault       = 1'b0;
        force_pulse = 1'b0;
        case (st)
            ST_IDLE, ST_SUCCESS: begin
                if (start) begin
                    nxt       = ST_PULSE;
                    tmr_ld    = 1'b1;
                    tmr_val   = TW'(PULSE_CYC);
                    rew_set   = 1'b1;
                    retry_nxt = '0;
                end
            end
            ST_PULSE: begin
                if (tmr_exp) begin
                    nxt     = ST_WAIT_STAT;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(STATUS_TO);
                end
            end
            ST_WAIT_STAT: begin
                if (tgt.stat_n) nxt = ST_STREAM;
                else if (tmr_exp) begin
                    fault       = 1'b1;
                    force_pulse = 1'b1;
                end
            end
            ST_STREAM: begin
                if (!tgt.stat_n)    fault = 1'b1;
                else if (last_latch) nxt = ST_TRAIL;
            end
            ST_TRAIL: begin
                if (!tgt.stat_n) fault = 1'b1;
                else if (trail_done) begin
                    nxt     = ST_DONE_WAIT;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(DONE_TO);
                end
            end
            ST_DONE_WAIT: begin
                if (!tgt.stat_n) fault = 1'b1;
                else if (tgt.done && tgt.init) nxt = ST_SUCCESS;
                else if (tmr_exp) begin
                    fault       = 1'b1;
                    force_pulse = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (tgt.stat_n) nxt = ST_STREAM;
                else if (tmr_exp) begin
                    fault       = 1'b1;
                    force_pulse = 1'b1;
                end
            end
            ST_FAIL: nxt = ST_FAIL;
            default: nxt = ST_IDLE;
        endcase

        if (fault) begin
            if (retry_q >= RW'(MAX_RETRY)) begin
                nxt = ST_FAIL;
            end else begin
                retry_nxt = retry_q + 1'b1;
                rew_set   = 1'b1;
                tmr_ld    = 1'b1;
                if (auto_restart && !force_pulse) begin
                    nxt     = ST_RECOVER;
                    tmr_val = TW'(STATUS_TO);
                end else begin
                    nxt     = ST_PULSE;
                    tmr_val = TW'(PULSE_CYC);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            retry_q <= '0;
            rew_q   <= 1'b0;
        end else begin
            st      <= nxt;
            retry_q <= retry_nxt;
            rew_q   <= rew_set;
        end
    end

    assign cfg_req_n = (st != ST_PULSE);
    assign rewind    = rew_q;
    assign ok        = (st == ST_SUCCESS);
    assign fail      = (st == ST_FAIL);

    // low-time tracker for the request pulse check
    logic [LW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst || cfg_req_n)             low_run <= '0;
        else if (low_run != LW'(PULSE_CYC)) low_run <= low_run + 1'b1;
    end

    AST_REQ_MIN_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_req_n) |-> (low_run >= LW'(PULSE_CYC))); // R2
    AST_READY_ONLY_STREAM: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (st == ST_STREAM)); // R6
    AST_CLK_GATED: assert property (@(posedge clk) disable iff (rst)
        cfg_clk |-> $past(st == ST_STREAM || st == ST_TRAIL)); // R6
    AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(ok) |-> $past(tgt.done && tgt.init)); // R5
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        fail |=> (fail && cfg_req_n && !cfg_clk)); // R10
    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
        retry_q <= RW'(MAX_RETRY)); // R10
    AST_REWIND_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rewind |=> !rewind); // R12
endmodule

// File: tb/pp_cfg_host_test.sv
module pp_cfg_host_test;
    localparam int NB    = 6;
    localparam int PULSE = 100;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 0, auto_restart = 0, comp_mode = 0;
    logic [7:0] s_data = '0;
    logic s_valid = 0, s_last = 0, s_ready, rewind;
    logic cfg_req_n, cfg_clk, ok, fail;
    logic [7:0] cfg_data;
    logic stat_n = 1, done_in = 0, init_in = 0;

    pp_cfg_host uut (
        .clk(clk), .rst(rst), .start(start), .auto_restart(auto_restart),
        .comp_mode(comp_mode), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
        .s_ready(s_ready), .rewind(rewind), .cfg_req_n(cfg_req_n), .cfg_data(cfg_data),
        .cfg_clk(cfg_clk), .stat_n(stat_n), .done_in(done_in), .init_in(init_in),
        .ok(ok), .fail(fail)
    );

    initial forever #10 clk = ~clk;

    int checks = 0, errors = 0;
    int idx = 0, ncap = 0, npulse = 0, nrew = 0, lowcnt = 0, min_low = 1000000;
    int rel = 0, err_cnt = 0, cyc = 0;
    bit fire = 0, stall_en = 0, done_en = 1, first_stat = 1;
    logic [7:0] cap [64];

    function automatic logic [7:0] pat(input int k);
        return 8'(((k * 53) + 17) ^ 8'h5A);
    endfunction

    function automatic int trail_exp();
        return comp_mode ? 3 : 2;
    endfunction

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // source, target model and request monitor, all on the falling edge
    initial forever begin
        @(negedge clk);
        cyc++;
        if (!cfg_req_n) lowcnt++;
        else if (lowcnt > 0) begin
            npulse++;
            if (lowcnt < min_low) min_low = lowcnt;
            lowcnt = 0;
        end
        if (fire) idx++;
        if (rewind) begin idx = 0; ncap = 0; nrew++; end
        if (!cfg_req_n) begin
            stat_n = 0; done_in = 0; init_in = 0; rel = 20; err_cnt = 0;
        end else if (rel > 0) begin
            rel--;
            if (rel == 0) stat_n = 1;
        end else if (err_cnt > 0) begin
            stat_n = 0;
            err_cnt--;
            if (err_cnt == 0) stat_n = 1;
        end else if (done_en && ncap >= NB + trail_exp()) begin
            done_in = 1; init_in = 1;
        end
        s_valid = (idx < NB) && (!stall_en || (cyc % 3) != 0);
        s_data  = pat((idx < NB) ? idx : 0);
        s_last  = (idx == NB - 1);
        #1 fire = s_valid && s_ready;
    end

    // target side capture on the configuration clock
    initial forever begin
        @(posedge cfg_clk);
        if (ncap == 0) first_stat = stat_n;
        if (ncap < 64) cap[ncap] = cfg_data;
        ncap++;
    end

    initial begin
        repeat (180000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_flag(input int which, input int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (which == 0 && ok) break;
            if (which == 1 && fail) break;
            if (which == 2 && ncap >= 3) break;
        end
    endtask

    task automatic check_image(input string req);
        int bad = 0;
        for (int k = 0; k < NB; k++) if (cap[k] !== pat(k)) bad++;
        chk(bad == 0, req, bad, 0);
        chk(ncap == NB + trail_exp(), req, ncap, NB + trail_exp());
        chk(first_stat == 1, "R2", first_stat, 1);
    endtask

    task automatic error_case(input bit autom, input int width, input string req);
        int p0, r0, n1, n2;
        auto_restart = autom; comp_mode = 0; stall_en = 0; done_en = 1;
        pulse_start();
        wait_flag(2, 3000);
        p0 = npulse; r0 = nrew;
        err_cnt = width;
        repeat (8) @(negedge clk);
        n1 = ncap;
        repeat (50) @(negedge clk);
        n2 = ncap;
        chk(n1 == n2, "R6", n2, n1);
        chk(cfg_clk == 0 && s_ready == 0, "R6", {cfg_clk, s_ready}, 0);
        wait_flag(0, width + 3000);
        chk(ok == 1, req, ok, 1);
        chk(nrew == r0 + 1, "R12", nrew, r0 + 1);
        check_image(req);
        if (autom) chk(npulse == p0, "R7", npulse, p0);
        else begin
            chk(npulse == p0 + 1, "R8", npulse, p0 + 1);
            chk(min_low >= PULSE, "R8", min_low, PULSE);
        end
    endtask

    initial begin
        int p0, r0;
        repeat (5) @(negedge clk);
        chk(cfg_req_n == 1 && cfg_clk == 0, "R1", {cfg_req_n, cfg_clk}, 2);
        rst = 0;
        @(negedge clk);
        chk({s_ready, rewind, ok, fail} == 4'b0, "R1", {s_ready, rewind, ok, fail}, 0);
        chk(cfg_req_n == 1 && cfg_clk == 0, "R1", {cfg_req_n, cfg_clk}, 2);

        // plain image, no stalls
        pulse_start();
        wait_flag(0, 5000);
        chk(ok == 1, "R5", ok, 1);
        chk(npulse == 1, "R2", npulse, 1);
        chk(min_low >= PULSE, "R2", min_low, PULSE);
        chk(nrew == 1, "R12", nrew, 1);
        check_image("R3");
        chk(cfg_clk == 0, "R4", cfg_clk, 0);
        repeat (20) @(negedge clk);
        chk(ncap == NB + 2 && ok == 1, "R4", ncap, NB + 2);

        // compressed image with stalls, restarted from success
        comp_mode = 1; stall_en = 1;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk(ok == 0 && cfg_req_n == 0, "R11", {ok, cfg_req_n}, 0);
        wait_flag(0, 5000);
        chk(ok == 1, "R11", ok, 1);
        check_image("R4");
        chk(npulse == 2, "R11", npulse, 2);

        // error recovery paths
        error_case(1'b1, 500,   "R7");
        error_case(1'b1, 25000, "R7");
        error_case(1'b0, 500,   "R8");

        // done never arrives: retries then sticky failure
        auto_restart = 0; comp_mode = 0; stall_en = 0; done_en = 0;
        p0 = npulse; r0 = nrew;
        pulse_start();
        wait_flag(1, 20000);
        chk(fail == 1 && ok == 0, "R10", fail, 1);
        chk(npulse == p0 + 3, "R9", npulse, p0 + 3);
        chk(nrew == r0 + 3, "R12", nrew, r0 + 3);
        pulse_start();
        repeat (300) @(negedge clk);
        chk(fail == 1 && cfg_req_n == 1 && cfg_clk == 0, "R10",
            {fail, cfg_req_n, cfg_clk}, 6);
        chk(npulse == p0 + 3, "R10", npulse, p0 + 3);

        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(fail == 0 && ok == 0 && cfg_req_n == 1, "R1", {fail, ok, cfg_req_n}, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule